// File: doc/BRIEF.md
# Modem Handshake Control and Status with Loopback

This block sits beside a serial port's data path and handles its handshake lines. A CPU-visible control register drives four active-low handshake outputs (terminal ready, request to send and two general-purpose auxiliary lines) and holds a loopback enable. A status register reports the present level of the four incoming handshake lines (clear to send, data set ready, ring and carrier detect). It also reports four sticky change flags. These flags raise an interrupt request and clear when the status register is read.

The incoming lines pass through a synchronizer before change detection. A two-state mode machine selects between live operation (state LIVE) and internal loopback (state LOOP). Writing the control register with the loopback bit at 1 takes the transition LIVE to LOOP. Writing it with the loopback bit at 0 takes LOOP to LIVE. Any other control write keeps the current state. In LOOP the handshake output pins are parked high and the serial output pin is held at mark (1). The transmitter's shift output is routed to the receiver input, and the status register sees the control bits in place of the external inputs.

Top module: `hsk_modem_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, all four handshake output pins and the serial output follow live mode (pins high), loopback select is 0, the interrupt request is 0 and the status register reads 0x00 while all input pins are high.
- R2: A control write (sel=0) drives each handshake pin to the inverse of its control bit: dtr_n_o from bit 0, rts_n_o from bit 1, aux1_n_o from bit 2, aux2_n_o from bit 3, visible the cycle after the write.
- R3: A control read (sel=0) returns bits 4:0 as last written and bits 7:5 as 0.
- R4: Status bits 4, 5, 6 and 7 report the complement of cts_n_i, dsr_n_i, ri_n_i and dcd_n_i respectively, after a synchronizer of SYNC_STAGES flops.
- R5: Status bit 0, bit 1 and bit 3 are set when the synchronized clear-to-send, data-set-ready or carrier-detect line changes in either direction.
- R6: Status bit 2 is set only when the ring pin ri_n_i goes from low to high; a high-to-low transition sets nothing.
- R7: A status read (sel=1, rd_en=1) clears bits 3:0 at that clock edge; a change detected at the same edge leaves its bit set.
- R8: msr_irq_o is high exactly when any of status bits 3:0 is set.
- R9: In loopback, status bits 4, 5, 6 and 7 equal control bits 1, 0, 2 and 3, change flags follow those bits, and the external handshake pins have no effect.
- R10: In loopback the four handshake pins are high, line_tx_o is 1 and rx_in_o equals tx_shift_i; in live mode line_tx_o equals tx_shift_i and rx_in_o equals line_rx_i.
- R11: A write with sel=1 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (status read clears change flags) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring pin, active low |
| dcd_n_i | input | 1 | Carrier-detect pin, active low |
| dtr_n_o | output | 1 | Terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| aux1_n_o | output | 1 | Auxiliary output 1, active low |
| aux2_n_o | output | 1 | Auxiliary output 2, active low |
| tx_shift_i | input | 1 | Transmit shift register output |
| line_rx_i | input | 1 | Serial input pin |
| line_tx_o | output | 1 | Serial output pin |
| rx_in_o | output | 1 | Serial bit fed to the receiver |
| lpbk_o | output | 1 | Loopback select |
| msr_irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench aims a line change at the very edge where a status read clears the flags. A design where the clear wins would lose that event and show bit 0 low afterwards. Ring is driven both ways: a design that flags the leading edge, or both edges, shows bit 2 after the falling pin or twice. In loopback the bench toggles the external pins and checks for no change, which catches a design that still listens to them. It also checks the crossed mapping of request-to-send onto bit 4 and terminal-ready onto bit 5, which a straight mapping gets wrong. Writes to the status address are checked for leaving the control register and mode intact.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
    // Mode state of the handshake block
    typedef enum logic {
        MODE_LIVE = 1'b0,
        MODE_LOOP = 1'b1
    } hsk_mode_e;

    localparam int HSK_LINES = 4;
    // Line indices (also change-flag positions in the status byte)
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;
    // Control register bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_AUX1 = 2;
    localparam int CB_AUX2 = 3;
    localparam int CB_LOOP = 4;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hsk_delta.sv
module hsk_delta #(
    parameter int           W          = 4,
    parameter logic [W-1:0] TRAIL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic         clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] prev_q;
    logic [W-1:0] change;

    // Lines in TRAIL_MASK flag only a 1-to-0 step of the active-high level
    for (genvar i = 0; i < W; i++) begin : g_det
        if (TRAIL_MASK[i]) begin : g_trail
            assign change[i] = prev_q[i] & ~cur[i];
        end else begin : g_any
            assign change[i] = prev_q[i] ^ cur[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flags  <= '0;
        end else begin
            prev_q <= cur;
            flags  <= (flags & ~{W{clr}}) | change;
        end
    end
endmodule

// File: rtl/hsk_modem_ctrl.sv
module hsk_modem_ctrl
    import hsk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    input  logic       ri_n_i,
    input  logic       dcd_n_i,
    output logic       dtr_n_o,
    output logic       rts_n_o,
    output logic       aux1_n_o,
    output logic       aux2_n_o,
    input  logic       tx_shift_i,
    input  logic       line_rx_i,
    output logic       line_tx_o,
    output logic       rx_in_o,
    output logic       lpbk_o,
    output logic       msr_irq_o
);
    localparam int NL = HSK_LINES;
    localparam logic [NL-1:0] RI_TRAIL = NL'(1) << LN_RI;

    hsk_mode_e     mode_q, mode_d;
    logic [NL-1:0] ctl_q;
    logic [NL-1:0] pins_n, pins_n_sync, live_lines, loop_lines, eff_lines;
    logic [NL-1:0] flags;
    logic [NL-1:0] out_pins_n;
    logic          ctl_wr, stat_rd;

    assign ctl_wr  = wr_en && !sel;
    assign stat_rd = rd_en && sel;

    // Mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_LIVE;
        else        mode_q <= mode_d;
    end

    // Mode transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LIVE: if (ctl_wr && wr_data[CB_LOOP])  mode_d = MODE_LOOP;
            MODE_LOOP: if (ctl_wr && !wr_data[CB_LOOP]) mode_d = MODE_LIVE;
            default:   mode_d = MODE_LIVE;
        endcase
    end

    // Output-control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= wr_data[NL-1:0];
    end

    // Input synchronizer (pins idle high)
    assign pins_n[LN_CTS] = cts_n_i;
    assign pins_n[LN_DSR] = dsr_n_i;
    assign pins_n[LN_RI]  = ri_n_i;
    assign pins_n[LN_DCD] = dcd_n_i;

    hsk_sync #(.W(NL), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_n),
        .q     (pins_n_sync)
    );

    assign live_lines = ~pins_n_sync;

    // Loopback feeds control bits back as line levels
    assign loop_lines[LN_CTS] = ctl_q[CB_RTS];
    assign loop_lines[LN_DSR] = ctl_q[CB_DTR];
    assign loop_lines[LN_RI]  = ctl_q[CB_AUX1];
    assign loop_lines[LN_DCD] = ctl_q[CB_AUX2];

    // Mode-dependent outputs
    always_comb begin
        unique case (mode_q)
            MODE_LIVE: begin
                eff_lines  = live_lines;
                out_pins_n = ~ctl_q;
                line_tx_o  = tx_shift_i;
                rx_in_o    = line_rx_i;
                lpbk_o     = 1'b0;
            end
            MODE_LOOP: begin
                eff_lines  = loop_lines;
                out_pins_n = '1;
                line_tx_o  = 1'b1;
                rx_in_o    = tx_shift_i;
                lpbk_o     = 1'b1;
            end
            default: begin
                eff_lines  = live_lines;
                out_pins_n = '1;
                line_tx_o  = 1'b1;
                rx_in_o    = line_rx_i;
                lpbk_o     = 1'b0;
            end
        endcase
    end

    assign dtr_n_o  = out_pins_n[CB_DTR];
    assign rts_n_o  = out_pins_n[CB_RTS];
    assign aux1_n_o = out_pins_n[CB_AUX1];
    assign aux2_n_o = out_pins_n[CB_AUX2];

    // Change detection: ring flags only its trailing edge
    hsk_delta #(.W(NL), .TRAIL_MASK(RI_TRAIL)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (eff_lines),
        .clr   (stat_rd),
        .flags (flags)
    );

    assign msr_irq_o = |flags;
    assign rd_data   = sel ? {eff_lines, flags}
                           : {3'b000, (mode_q == MODE_LOOP), ctl_q};
endmodule

// File: rtl/hsk_modem_ctrl_chk.sv
module hsk_modem_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       dtr_n_o,
    input logic       rts_n_o,
    input logic       aux1_n_o,
    input logic       aux2_n_o,
    input logic       tx_shift_i,
    input logic       line_rx_i,
    input logic       line_tx_o,
    input logic       rx_in_o,
    input logic       lpbk_o,
    input logic       msr_irq_o,
    input logic [3:0] ctl_q
);
    // R2
    ctl_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel && !wr_data[4]) |=>
        ({aux2_n_o, aux1_n_o, rts_n_o, dtr_n_o} == ~$past(wr_data[3:0])));

    // R3
    ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rd_data[7:5] == 3'b000));

    // R8
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (msr_irq_o == (|rd_data[3:0])));

    // R9
    loop_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_o && sel) |-> (rd_data[7:4] == {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]}));

    // R10
    loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_o |-> ({aux2_n_o, aux1_n_o, rts_n_o, dtr_n_o} == 4'hF
                    && line_tx_o && (rx_in_o == tx_shift_i)));

    // R10
    live_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lpbk_o |-> ((line_tx_o == tx_shift_i) && (rx_in_o == line_rx_i)));

    // R11
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel) |=> ((ctl_q == $past(ctl_q)) && (lpbk_o == $past(lpbk_o))));
endmodule

bind hsk_modem_ctrl hsk_modem_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .dtr_n_o    (dtr_n_o),
    .rts_n_o    (rts_n_o),
    .aux1_n_o   (aux1_n_o),
    .aux2_n_o   (aux2_n_o),
    .tx_shift_i (tx_shift_i),
    .line_rx_i  (line_rx_i),
    .line_tx_o  (line_tx_o),
    .rx_in_o    (rx_in_o),
    .lpbk_o     (lpbk_o),
    .msr_irq_o  (msr_irq_o),
    .ctl_q      (ctl_q)
);

// File: tb/hsk_modem_ctrl_tb.sv
module hsk_modem_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       dtr_n, rts_n, aux1_n, aux2_n;
    logic       tx_shift = 1'b0, line_rx = 1'b0;
    logic       line_tx, rx_in, lpbk, irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #2 clk = ~clk;  // 250 MHz

    hsk_modem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .dcd_n_i(dcd_n),
        .dtr_n_o(dtr_n), .rts_n_o(rts_n), .aux1_n_o(aux1_n), .aux2_n_o(aux2_n),
        .tx_shift_i(tx_shift), .line_rx_i(line_rx), .line_tx_o(line_tx),
        .rx_in_o(rx_in), .lpbk_o(lpbk), .msr_irq_o(irq)
    );

    // Vector: {pins dcd_n,ri_n,dsr_n,cts_n ; expected status byte}
    localparam int NV = 9;
    localparam logic [11:0] VEC [NV] = '{
        {4'b1110, 8'h11}, {4'b1010, 8'h50}, {4'b1110, 8'h14},
        {4'b0111, 8'h89}, {4'b0101, 8'hA2}, {4'b1111, 8'h0A},
        {4'b1111, 8'h00}, {4'b0000, 8'hFB}, {4'b1111, 8'h0F}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        @(negedge clk);
        {dcd_n, ri_n, dsr_n, cts_n} = p;
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read with strobe; value sampled before the clearing edge
    task automatic rd(input logic s, output logic [7:0] v);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        rd(1'b0, v); check("R1 ctl", v, 8'h00);
        rd(1'b1, v); check("R1 status", v, 8'h00);
        check("R1 pins", {4'h0, aux2_n, aux1_n, rts_n, dtr_n}, 8'h0F);
        check("R1 irq/lpbk", {6'h0, irq, lpbk}, 8'h00);

        // Table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            set_pins(VEC[i][11:8]);
            settle();
            @(negedge clk); sel = 1'b1;
            #1 check("R8 irq", {7'h0, irq}, {7'h0, |VEC[i][3:0]});
            rd(1'b1, v); check("R4/R5/R6 status", v, VEC[i][7:0]);
            @(negedge clk); sel = 1'b1;
            #1 check("R7 cleared", v & 8'h0F & rd_data, 8'h00);
        end

        // R2 / R3 control write and readback
        wr(1'b0, 8'hE5);
        check("R2 pins", {4'h0, aux2_n, aux1_n, rts_n, dtr_n}, 8'h0A);
        rd(1'b0, v); check("R3 readback", v, 8'h05);
        wr(1'b0, 8'h0F);
        check("R2 pins all", {4'h0, aux2_n, aux1_n, rts_n, dtr_n}, 8'h00);

        // R11 status write ignored
        wr(1'b1, 8'hFF);
        rd(1'b0, v); check("R11 ctl", v, 8'h0F);
        rd(1'b1, v); check("R11 status", v, 8'h00);
        wr(1'b0, 8'h00);

        // R7 change at the clearing edge: pin at N0, flag set at P3
        @(negedge clk); cts_n = 1'b0;
        @(negedge clk);
        @(negedge clk); sel = 1'b1; rd_en = 1'b1;
        #1 check("R7 pre", rd_data, 8'h10);
        @(negedge clk); rd_en = 1'b0;
        #1 check("R7 set wins", rd_data, 8'h11);
        rd(1'b1, v);
        set_pins(4'b1111); settle(); rd(1'b1, v);
        check("R7 back", v, 8'h01);

        // R9 / R10 loopback
        tx_shift = 1'b0; line_rx = 1'b1;
        wr(1'b0, 8'h10);
        check("R10 loop pins", {2'b0, line_tx, rx_in, aux2_n, aux1_n, rts_n, dtr_n}, 8'h2F);
        tx_shift = 1'b1; line_rx = 1'b0; #1
        check("R10 loop rx", {7'h0, rx_in}, 8'h01);
        rd(1'b0, v); check("R3 loop bit", v, 8'h10);
        rd(1'b1, v); check("R9 entry", v, 8'h00);
        wr(1'b0, 8'h13);
        check("R10 pins parked", {4'h0, aux2_n, aux1_n, rts_n, dtr_n}, 8'h0F);
        settle(); rd(1'b1, v); check("R9 rts/dtr", v, 8'h33);
        set_pins(4'b0000); settle();
        rd(1'b1, v); check("R9 pins ignored", v, 8'h30);
        set_pins(4'b1111); settle();
        wr(1'b0, 8'h14); settle();
        rd(1'b1, v); check("R9 out1", v, 8'h43);
        wr(1'b0, 8'h10); settle();
        rd(1'b1, v); check("R6 loop trailing", v, 8'h04);
        wr(1'b0, 8'h00); settle();
        rd(1'b1, v); check("R10 exit status", v, 8'h00);
        tx_shift = 1'b0; line_rx = 1'b1; #1
        check("R10 live path", {6'h0, line_tx, rx_in, lpbk}, {5'h0, 1'b0, 1'b1, 1'b0});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule